// File: doc/BRIEF.md
# Banked Pulse and Level Reset Controller

This block drives one active-high reset output for every line in a configurable number of banks, each bank holding 32 lines. Software reaches it through a plain register bus made of an address, a write strobe, write data and read data. There are two independent ways to put a line into reset. The first is a write-only trigger word per bank: every 1 bit written there starts a self-timed pulse on the matching line. The second is a held level word per bank, placed at a parameterised byte offset, where a 0 bit keeps the line in reset until software writes it back to 1.

Line N belongs to bank N/32 at bit N%32, so the output vector is simply the banks laid side by side. The output of a line is the OR of its pulse activity and the inverse of its level bit. Level words read back their stored value, so single bits can be changed by read-modify-write. The bus carries register accesses and no data stream, so it has no valid/ready handshake. A write takes effect at the clock edge where `wr_en` is high. Reads are combinational from `addr`.

Top module: `bank_reset_ctrl`

## Requirements
- R1: While `rst_n` is low and right after it is released, every `rst_out` bit is 0 and every level word reads 0xFFFFFFFF.
- R2: A write to byte address 4*B (B below NUM_BANKS) with bit i set drives `rst_out[32*B+i]` high. It goes high in the cycle after the write edge and stays high for exactly PULSE_CYCLES cycles.
- R3: Bits written as 0 to a trigger word leave their lines unchanged, including lines whose pulse is already running, and one write can start pulses on several lines.
- R4: Writing 1 again to a line whose pulse is running restarts its count, so the line stays high for PULSE_CYCLES cycles after the latest write.
- R5: A write to byte address LEVEL_OFFSET+4*B stores `wr_data` in level word B, and a read of that address returns the stored word.
- R6: A level bit of 0 holds its line's `rst_out` high and a bit of 1 releases it, so `rst_out` is the OR of the pulse activity and the inverted level bit.
- R7: Reads of trigger word addresses return 0.
- R8: Addresses with `addr[1:0]` not 0, addresses past the last configured bank of either region, and all other addresses outside both regions read as 0. Writes to them change no level word and start no pulse.
- R9: Line N is controlled by bit N%32 of the words for bank N/32, and it drives `rst_out[N]` only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register and pulse clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block |
| addr | input | ADDR_W | Byte address of the access, word aligned |
| wr_en | input | 1 | Write strobe, sampled at the rising edge |
| wr_data | input | 32 | Data written to the addressed word |
| rd_data | output | 32 | Combinational read of the addressed word |
| rst_out | output | NUM_BANKS*32 | Active-high reset per line |

## Verification
A level write shows on `rst_out` and on `rd_data` one edge after the write. A trigger write raises its lines in the cycle after the write edge, and they fall exactly PULSE_CYCLES cycles later. `rd_data` follows `addr` in the same cycle. The bench drives inputs on the falling edge and runs a cycle model that updates on the rising edge. At each falling edge it compares `rst_out` against the model before it changes any input, and it compares `rd_data` one nanosecond after it sets the new address. The directed cases count falling edges to measure pulse length after single writes and after a restart.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int unsigned LINES_PER_BANK = 32;

  typedef logic [LINES_PER_BANK-1:0] word_t;

  typedef enum logic [1:0] {
    REGION_NONE  = 2'd0,
    REGION_PULSE = 2'd1,
    REGION_LEVEL = 2'd2
  } region_e;
endpackage

// File: rtl/rstc_addr_decode.sv
module rstc_addr_decode
  import rstc_pkg::*;
#(
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned NUM_BANKS    = 8,
  parameter int unsigned LEVEL_OFFSET = 32'h7c,
  parameter int unsigned BANK_W       = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [BANK_W-1:0] bank
);
  localparam logic [31:0] PULSE_END = 32'(4 * NUM_BANKS);
  localparam logic [31:0] LEVEL_BEG = 32'(LEVEL_OFFSET);
  localparam logic [31:0] LEVEL_END = 32'(LEVEL_OFFSET + 4 * NUM_BANKS);

  logic [31:0] byte_addr;
  logic [31:0] level_rel;

  assign byte_addr = 32'(addr);
  assign level_rel = byte_addr - LEVEL_BEG;

  // Trigger region is tested first, so it wins if the two ever overlap.
  always_comb begin
    region = REGION_NONE;
    bank   = '0;
    if (addr[1:0] == 2'b00) begin
      if (byte_addr < PULSE_END) begin
        region = REGION_PULSE;
        bank   = BANK_W'(byte_addr >> 2);
      end else if ((byte_addr >= LEVEL_BEG) && (byte_addr < LEVEL_END)) begin
        region = REGION_LEVEL;
        bank   = BANK_W'(level_rel >> 2);
      end
    end
  end
endmodule

// File: rtl/rstc_pulse_bank.sv
module rstc_pulse_bank
  import rstc_pkg::*;
#(
  parameter int unsigned PULSE_CYCLES = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  word_t trig,
  output word_t active
);
  localparam int unsigned CNT_W = $clog2(PULSE_CYCLES + 1);

  // One down-counter per line; a trigger bit reloads it.
  for (genvar i = 0; i < LINES_PER_BANK; i++) begin : g_line
    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        remain <= '0;
      end else if (trig[i]) begin
        remain <= CNT_W'(PULSE_CYCLES);
      end else if (remain != '0) begin
        remain <= remain - 1'b1;
      end
    end

    assign active[i] = (remain != '0);
  end
endmodule

// File: rtl/rstc_level_bank.sv
module rstc_level_bank
  import rstc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  we,
  input  word_t wdata,
  output word_t held
);
  // Active-low hold bits; all lines released out of reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= '1;
    end else if (we) begin
      held <= wdata;
    end
  end
endmodule

// File: rtl/bank_reset_ctrl.sv
module bank_reset_ctrl
  import rstc_pkg::*;
#(
  parameter int unsigned NUM_BANKS    = 8,
  parameter int unsigned LEVEL_OFFSET = 32'h7c,
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned PULSE_CYCLES = 16
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [ADDR_W-1:0]                   addr,
  input  logic                                wr_en,
  input  logic [31:0]                         wr_data,
  output logic [31:0]                         rd_data,
  output logic [NUM_BANKS*LINES_PER_BANK-1:0] rst_out
);
  localparam int unsigned NUM_LINES = NUM_BANKS * LINES_PER_BANK;
  localparam int unsigned BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  region_e              region;
  logic [BANK_W-1:0]    bank;
  word_t                held_words [NUM_BANKS];
  logic [NUM_LINES-1:0] level_q;

  rstc_addr_decode #(
    .ADDR_W      (ADDR_W),
    .NUM_BANKS   (NUM_BANKS),
    .LEVEL_OFFSET(LEVEL_OFFSET),
    .BANK_W      (BANK_W)
  ) u_dec (
    .addr  (addr),
    .region(region),
    .bank  (bank)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic  sel;
    word_t trig;
    word_t active;
    logic  lvl_we;

    assign sel    = (bank == BANK_W'(b));
    assign trig   = (wr_en && sel && (region == REGION_PULSE)) ? wr_data : '0;
    assign lvl_we = wr_en && sel && (region == REGION_LEVEL);

    rstc_pulse_bank #(
      .PULSE_CYCLES(PULSE_CYCLES)
    ) u_pulse (
      .clk   (clk),
      .rst_n (rst_n),
      .trig  (trig),
      .active(active)
    );

    rstc_level_bank u_level (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (lvl_we),
      .wdata(wr_data),
      .held (held_words[b])
    );

    assign level_q[b*LINES_PER_BANK +: LINES_PER_BANK] = held_words[b];
    assign rst_out[b*LINES_PER_BANK +: LINES_PER_BANK] = active | ~held_words[b];
  end

  // Only level words read back; trigger words and holes read as zero.
  always_comb begin
    rd_data = '0;
    if (region == REGION_LEVEL) begin
      rd_data = held_words[bank];
    end
  end
endmodule

// File: rtl/bank_reset_ctrl_chk.sv
module bank_reset_ctrl_chk #(
  parameter int unsigned NUM_BANKS    = 8,
  parameter int unsigned LEVEL_OFFSET = 32'h7c,
  parameter int unsigned ADDR_W       = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [ADDR_W-1:0]         addr,
  input logic                      wr_en,
  input logic [31:0]               wr_data,
  input logic [31:0]               rd_data,
  input logic [NUM_BANKS*32-1:0]   rst_out,
  input logic [NUM_BANKS*32-1:0]   level_q
);
  localparam int unsigned NL = NUM_BANKS * 32;

  logic [31:0]   a32;
  logic          aligned;
  logic          in_pulse;
  logic          in_level;
  logic [31:0]   pword;
  logic [31:0]   lword;
  logic [NL-1:0] trig_all;

  assign a32      = 32'(addr);
  assign aligned  = (addr[1:0] == 2'b00);
  assign in_pulse = aligned && (a32 < 32'(4 * NUM_BANKS));
  assign in_level = aligned && !in_pulse && (a32 >= 32'(LEVEL_OFFSET))
                    && (a32 < 32'(LEVEL_OFFSET + 4 * NUM_BANKS));
  assign pword    = a32 >> 2;
  assign lword    = (a32 - 32'(LEVEL_OFFSET)) >> 2;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_b
    assign trig_all[b*32 +: 32] = (wr_en && in_pulse && (pword == 32'(b))) ? wr_data : '0;

    AST_LEVEL_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && in_level && (lword == 32'(b))) |=> (level_q[b*32 +: 32] == $past(wr_data))); // R5
  end

  AST_TRIG_RAISES_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && in_pulse) |=> ((rst_out & $past(trig_all)) == $past(trig_all))); // R2

  AST_TRIG_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    in_pulse |-> (rd_data == 32'd0)); // R7

  AST_HOLE_KEEPS_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !in_pulse && !in_level) |=> $stable(level_q)); // R8

  AST_HOLE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_pulse && !in_level) |-> (rd_data == 32'd0)); // R8

  AST_LEVEL_LOW_HOLDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    ((rst_out | level_q) == {NL{1'b1}})); // R6
endmodule

bind bank_reset_ctrl bank_reset_ctrl_chk #(
  .NUM_BANKS   (NUM_BANKS),
  .LEVEL_OFFSET(LEVEL_OFFSET),
  .ADDR_W      (ADDR_W)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .addr   (addr),
  .wr_en  (wr_en),
  .wr_data(wr_data),
  .rd_data(rd_data),
  .rst_out(rst_out),
  .level_q(level_q)
);

// File: tb/sim_bank_reset_ctrl.sv
module sim_bank_reset_ctrl;
  localparam int NB   = 8;
  localparam int OFS  = 'h7c;
  localparam int AW   = 8;
  localparam int PW   = 16;
  localparam int NL   = NB * 32;
  localparam logic [AW-1:0] IDLE = 8'hF0;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = IDLE;
  logic          wr_en = 1'b0;
  logic [31:0]   wr_data = '0;
  logic [31:0]   rd_data;
  logic [NL-1:0] rst_out;

  int vectors = 0;
  int errors  = 0;
  logic [NL-1:0] seen;

  logic [31:0] m_level [NB];
  int          m_cnt   [NL];

  always #5 clk = ~clk;

  bank_reset_ctrl #(
    .NUM_BANKS(NB), .LEVEL_OFFSET(OFS), .ADDR_W(AW), .PULSE_CYCLES(PW)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .rst_out(rst_out)
  );

  // 0 none, 1 trigger word, 2 level word
  function automatic int region_of(input logic [AW-1:0] a);
    int v = int'(a);
    if (a[1:0] != 2'b00) return 0;
    if (v < 4 * NB) return 1;
    if (v >= OFS && v < OFS + 4 * NB) return 2;
    return 0;
  endfunction

  function automatic int bank_of(input logic [AW-1:0] a);
    int v = int'(a);
    return (region_of(a) == 1) ? (v >> 2) : ((v - OFS) >> 2);
  endfunction

  function automatic logic [NL-1:0] exp_out();
    logic [NL-1:0] e;
    for (int l = 0; l < NL; l++)
      e[l] = (m_cnt[l] > 0) || !m_level[l / 32][l % 32];
    return e;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [AW-1:0] a);
    if (region_of(a) == 2) return m_level[bank_of(a)];
    return 32'd0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) m_level[b] = '1;
      for (int l = 0; l < NL; l++) m_cnt[l] = 0;
    end else begin
      for (int l = 0; l < NL; l++) if (m_cnt[l] > 0) m_cnt[l]--;
      if (wr_en && region_of(addr) == 1) begin
        for (int i = 0; i < 32; i++)
          if (wr_data[i]) m_cnt[bank_of(addr) * 32 + i] = PW;
      end else if (wr_en && region_of(addr) == 2) begin
        m_level[bank_of(addr)] = wr_data;
      end
    end
  end

  task automatic check_out(input string req);
    logic [NL-1:0] e = exp_out();
    vectors++;
    if (rst_out !== e) begin
      errors++;
      $display("FAIL %s: rst_out got %h exp %h", req, rst_out, e);
    end
  endtask

  task automatic check_rd(input string req);
    logic [31:0] e = exp_rd(addr);
    vectors++;
    if (rd_data !== e) begin
      errors++;
      $display("FAIL %s: rd_data @%h got %h exp %h", req, addr, rd_data, e);
    end
  endtask

  task automatic check_val(input string req, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d exp %0d", req, got, exp);
    end
  endtask

  task automatic step(input logic [AW-1:0] a, input logic we,
                      input logic [31:0] d, input string req);
    @(negedge clk);
    seen = rst_out;
    check_out(req);
    addr = a; wr_en = we; wr_data = d;
    #1;
    check_rd(req);
  endtask

  task automatic measure(input int line, input string req, output int n);
    n = 0;
    for (int k = 0; k < 4 * PW; k++) begin
      step(IDLE, 1'b0, '0, req);
      if (seen[line]) n++;
      else if (n > 0) break;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd1234));
    // R1: reset state
    #22;
    check_val("R1 rst_out idle in reset", int'(rst_out != '0), 0);
    addr = 8'(OFS); #1;
    check_val("R1 level reads ones in reset", int'(rd_data != 32'hFFFF_FFFF), 0);
    @(negedge clk); rst_n = 1'b1;
    for (int b = 0; b < NB; b++) step(8'(OFS + 4 * b), 1'b0, '0, "R1");

    // R2, R9: single pulse on line 37 (bank 1, bit 5)
    step(8'd4, 1'b1, 32'h20, "R2");
    step(IDLE, 1'b0, '0, "R2");
    step(IDLE, 1'b0, '0, "R9");
    check_val("R9 only line 37 high", int'(seen == (NL'(1) << 37)), 1);
    measure(37, "R2", n);
    check_val("R2 pulse length", n + 2, PW);

    // R4: restart during pulse
    step(8'd0, 1'b1, 32'h8, "R4");
    for (int k = 0; k < 6; k++) step(IDLE, 1'b0, '0, "R4");
    step(8'd0, 1'b1, 32'h8, "R4");
    measure(3, "R4", n);
    check_val("R4 length after restart", n, PW);

    // R3: several lines in one write, zero bits leave a running pulse alone
    step(8'd8, 1'b1, 32'h8000_0011, "R3");
    step(IDLE, 1'b0, '0, "R3");
    step(8'd8, 1'b1, 32'h0000_0001, "R3");
    for (int k = 0; k < PW; k++) step(IDLE, 1'b0, '0, "R3");

    // R5, R6: level words
    step(8'(OFS), 1'b1, 32'hFFFF_FFFE, "R5");
    step(8'(OFS), 1'b0, '0, "R6");
    step(IDLE, 1'b0, '0, "R6");
    check_val("R6 line 0 held", int'(seen[0]), 1);
    step(8'(OFS + 4 * (NB - 1)), 1'b1, 32'h5A5A_0F0F, "R5");
    step(8'(OFS + 4 * (NB - 1)), 1'b0, '0, "R5");
    step(8'(OFS), 1'b1, 32'hFFFF_FFFF, "R6");
    step(8'(OFS + 4 * (NB - 1)), 1'b1, 32'hFFFF_FFFF, "R6");

    // R7: trigger words read zero
    step(8'd12, 1'b1, 32'hFFFF_FFFF, "R7");
    step(8'd12, 1'b0, '0, "R7");

    // R8: holes
    step(8'(4 * NB), 1'b1, 32'hFFFF_FFFF, "R8");
    step(8'(OFS + 4 * NB), 1'b1, 32'h0, "R8");
    step(8'(OFS + 1), 1'b1, 32'h0, "R8");
    step(8'(OFS - 4), 1'b1, 32'h0, "R8");
    step(8'd1, 1'b1, 32'hFFFF_FFFF, "R8");
    for (int b = 0; b < NB; b++) step(8'(OFS + 4 * b), 1'b0, '0, "R8");
    for (int k = 0; k < PW + 2; k++) step(IDLE, 1'b0, '0, "R8");

    // random mix against the model
    for (int k = 0; k < 4000; k++) begin
      logic [AW-1:0] a;
      logic [31:0] d;
      case ($urandom % 4)
        0: a = 8'(($urandom % NB) * 4);
        1: a = 8'(OFS + ($urandom % NB) * 4);
        2: a = 8'($urandom);
        default: a = 8'(OFS + ($urandom % NB) * 4 + 1 + $urandom % 3);
      endcase
      d = ($urandom % 2) ? (32'd1 << ($urandom % 32)) : ($urandom & $urandom & $urandom);
      if (region_of(a) == 2 && ($urandom % 2)) d = ~d;
      step(a, ($urandom % 3) != 0, d, "R2/R3/R4/R5/R6/R8 random");
    end
    for (int k = 0; k < PW + 2; k++) step(IDLE, 1'b0, '0, "R3 drain");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule